// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA bus for PIO and multiword DMA cycles. A 32-bit timing word sets every phase length. The word holds two separate sets of counts. One set is for accesses to the task-file registers. The other set is for data-port accesses. Each set has a setup count, an active count and an inactive count. Every phase lasts its field value plus one clock cycle.

The timing word is held in a register inside the block, and software loads it in one of two ways. A PIO-mode load replaces only the bits that PIO timing owns. A multiword-DMA load replaces only the bits that DMA timing owns. All other bits keep their values.

A burst runs as follows:
1. A start request arrives.
2. The block picks the count set with the access-type flag.
3. It runs one setup interval.
4. It alternates active and inactive strobe phases, once per word.
5. It raises a one-cycle done flag.

A per-word pulse marks the end of each active phase, so that the datapath can move a word.

Top module: `pio_strobe_gen`

## Requirements
- R1: During and just after reset, both strobes are high and word_pulse and done are low. The timing register resets to all zeros, so a burst started with no load uses one cycle for each phase.
- R2: With cfg_we=1 and cfg_dma=0, the register takes cfg_word on the bits under mask 0xCFC3FFFF. All other bits keep their old values.
- R3: With cfg_we=1 and cfg_dma=1, the register takes cfg_word on the bits under mask 0x31C001FF. All other bits keep their old values.
- R4: For a data access (tf_sel=0), the setup time comes from bits 24:22, the active time from bits 8:4 and the inactive time from bits 3:0. Each phase lasts its field value plus one cycle.
- R5: For a task-file access (tf_sel=1), the setup time comes from bits 27:25, the active time from bits 17:13 and the inactive time from bits 12:9. Each phase lasts its field value plus one cycle.
- R6: The setup interval comes only before the first word. The first setup cycle is the cycle after the edge that accepts start. Each later word starts its active phase right after the previous inactive phase.
- R7: With wr_sel=1 only diow_n goes low; with wr_sel=0 only dior_n goes low. The other strobe stays high for the whole burst.
- R8: word_pulse is high for exactly one cycle, the first cycle of each inactive phase. There is one pulse per word.
- R9: done is high for exactly one cycle, the cycle right after the last inactive phase. Both strobes are high in that cycle.
- R10: The timing fields are captured at the edge that accepts start. A configuration load or a new start during a burst does not change that burst.
- R11: burst_len holds the word count minus one. The value 255 gives a burst of 256 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ATA clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the timing register from cfg_word |
| cfg_dma | input | 1 | Load mask select: 0 = PIO mask, 1 = multiword DMA mask |
| cfg_word | input | 32 | New timing word |
| start | input | 1 | Start a burst (accepted only when idle) |
| tf_sel | input | 1 | 1 = task-file access counts, 0 = data access counts |
| wr_sel | input | 1 | 1 = write (diow_n), 0 = read (dior_n) |
| burst_len | input | LEN_W | Words in the burst minus one |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| word_pulse | output | 1 | One-cycle pulse at the start of each inactive phase |
| done | output | 1 | One-cycle pulse after the last inactive phase |

## Verification
Let S, A and R be the captured field values, N the word count, and P = A + R + 2. A start accepted at an edge puts the first setup cycle in the next cycle. The first active cycle is cycle S + 2 after that edge. Word k (counting from 0) is low from offset k·P through k·P + A of the word region, and its word_pulse comes at offset k·P + A + 1. done falls in cycle S + 1 + N·P + 1. The bench builds this whole cycle map from its own copy of the timing register and compares every cycle of the burst against it, sampling on the falling edge, until the done cycle. Changes made during a burst are applied to the bench's copy only after that burst ends.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int WORD_W  = 32;
    localparam int SETUP_W = 3;
    localparam int ACT_W   = 5;
    localparam int REC_W   = 4;
    localparam int CNT_W   = (ACT_W > REC_W) ? ((ACT_W > SETUP_W) ? ACT_W : SETUP_W)
                                             : ((REC_W > SETUP_W) ? REC_W : SETUP_W);

    localparam logic [WORD_W-1:0] PIO_MASK = 32'hCFC3_FFFF;
    localparam logic [WORD_W-1:0] MWD_MASK = 32'h31C0_01FF;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   act;
        logic [REC_W-1:0]   rec;
    } phase_times_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_REC
    } phase_t;

    // Pick the count set for a task-file or a data-port access
    function automatic phase_times_t pick_times(input logic [WORD_W-1:0] w, input logic tf);
        phase_times_t t;
        if (tf) begin
            t.setup = w[27:25];
            t.act   = w[17:13];
            t.rec   = w[12:9];
        end else begin
            t.setup = w[24:22];
            t.act   = w[8:4];
            t.rec   = w[3:0];
        end
        return t;
    endfunction

    // Replace only the bits owned by the selected mode
    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] new_w,
                                                     input logic dma);
        logic [WORD_W-1:0] m;
        m = dma ? MWD_MASK : PIO_MASK;
        return (old_w & ~m) | (new_w & m);
    endfunction

endpackage

// File: rtl/pio_timing_reg.sv
module pio_timing_reg
    import pio_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              dma,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= merge_word(q, wdata, dma);
        end
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_strobe_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tf,
    input  logic              wr,
    input  logic [LEN_W-1:0]  len,
    input  logic [WORD_W-1:0] word_in,
    output logic              rd_n,
    output logic              wr_n,
    output logic              word_pulse,
    output logic              done,
    output logic              busy
);

    phase_t            phase;
    phase_times_t      times_q;
    phase_times_t      sel_times;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  left;
    logic              wr_q;

    always_comb begin
        sel_times = pick_times(word_in, tf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            times_q    <= '0;
            cnt        <= '0;
            left       <= '0;
            wr_q       <= 1'b0;
            word_pulse <= 1'b0;
            done       <= 1'b0;
        end else begin
            word_pulse <= 1'b0;
            done       <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        times_q <= sel_times;
                        wr_q    <= wr;
                        left    <= len;
                        cnt     <= CNT_W'(sel_times.setup);
                        phase   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_W'(times_q.act);
                        phase <= PH_ACT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACT: begin
                    if (cnt == '0) begin
                        cnt        <= CNT_W'(times_q.rec);
                        phase      <= PH_REC;
                        word_pulse <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_REC: begin
                    if (cnt == '0) begin
                        if (left == '0) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            left  <= left - 1'b1;
                            cnt   <= CNT_W'(times_q.act);
                            phase <= PH_ACT;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign rd_n = !((phase == PH_ACT) && !wr_q);
    assign wr_n = !((phase == PH_ACT) &&  wr_q);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_dma,
    input  logic [31:0]      cfg_word,
    input  logic             start,
    input  logic             tf_sel,
    input  logic             wr_sel,
    input  logic [LEN_W-1:0] burst_len,
    output logic             dior_n,
    output logic             diow_n,
    output logic             word_pulse,
    output logic             done
);

    logic [WORD_W-1:0] timing_q;
    logic              busy;

    pio_timing_reg u_treg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .dma   (cfg_dma),
        .wdata (cfg_word),
        .q     (timing_q)
    );

    pio_phase_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tf         (tf_sel),
        .wr         (wr_sel),
        .len        (burst_len),
        .word_in    (timing_q),
        .rd_n       (dior_n),
        .wr_n       (diow_n),
        .word_pulse (word_pulse),
        .done       (done),
        .busy       (busy)
    );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
    input logic clk,
    input logic rst,
    input logic dior_n,
    input logic diow_n,
    input logic word_pulse,
    input logic done,
    input logic busy
);

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dior_n && diow_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (dior_n && diow_n && !busy));

    assert_pulse_after_act_R8: assert property (@(posedge clk) disable iff (rst)
        word_pulse |-> (dior_n && diow_n && !$past(dior_n && diow_n)));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        word_pulse |=> !word_pulse);

endmodule

bind pio_strobe_gen pio_strobe_gen_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .word_pulse (word_pulse),
    .done       (done),
    .busy       (busy)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic             cfg_dma = 1'b0;
    logic [31:0]      cfg_word = '0;
    logic             start = 1'b0;
    logic             tf_sel = 1'b0;
    logic             wr_sel = 1'b0;
    logic [LEN_W-1:0] burst_len = '0;
    logic             dior_n;
    logic             diow_n;
    logic             word_pulse;
    logic             done;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;
    logic [31:0] model_word = '0;

    pio_strobe_gen #(.LEN_W(LEN_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_dma    (cfg_dma),
        .cfg_word   (cfg_word),
        .start      (start),
        .tf_sel     (tf_sel),
        .wr_sel     (wr_sel),
        .burst_len  (burst_len),
        .dior_n     (dior_n),
        .diow_n     (diow_n),
        .word_pulse (word_pulse),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] apply_load(input logic [31:0] old_w, input logic [31:0] new_w, input bit dma);
        logic [31:0] m;
        m = dma ? 32'h31C0_01FF : 32'hCFC3_FFFF;
        return (old_w & ~m) | (new_w & m);
    endfunction

    task automatic cfg_write(input logic [31:0] w, input bit dma);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dma = dma; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        model_word = apply_load(model_word, w, dma);
    endtask

    task automatic run_burst(input bit tf, input bit wr, input int len, input bit poke, input string extra);
        int s, a, r, n, p, total;
        int bad_sel, bad_oth, bad_pulse, bad_done;
        logic [31:0] poke_word;
        bit pend;
        s = tf ? int'(model_word[27:25]) : int'(model_word[24:22]);
        a = tf ? int'(model_word[17:13]) : int'(model_word[8:4]);
        r = tf ? int'(model_word[12:9])  : int'(model_word[3:0]);
        n = len + 1;
        p = a + r + 2;
        total = s + 1 + n * p;
        bad_sel = 0; bad_oth = 0; bad_pulse = 0; bad_done = 0;
        poke_word = ~model_word;
        pend = 0;
        @(negedge clk);
        start = 1'b1; tf_sel = tf; wr_sel = wr; burst_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= total + 1; i++) begin
            bit exp_low, exp_pulse, exp_done;
            logic sel, oth;
            exp_low = 0; exp_pulse = 0;
            exp_done = (i == total + 1);
            if (i > s + 1 && i <= total) begin
                int o;
                o = (i - s - 2) % p;
                exp_low = (o <= a);
                exp_pulse = (o == a + 1);
            end
            sel = wr ? diow_n : dior_n;
            oth = wr ? dior_n : diow_n;
            if (sel !== !exp_low) bad_sel++;
            if (oth !== 1'b1) bad_oth++;
            if (word_pulse !== exp_pulse) bad_pulse++;
            if (done !== exp_done) bad_done++;
            if (poke && i == 2) begin
                start = 1'b1; tf_sel = !tf; wr_sel = !wr; burst_len = '0;
                cfg_we = 1'b1; cfg_dma = 1'b0; cfg_word = poke_word;
                pend = 1;
            end else begin
                start = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; cfg_we = 1'b0;
        if (pend) model_word = apply_load(model_word, poke_word, 1'b0);
        chk(bad_sel == 0, tf ? "R5" : "R4", "selected strobe mismatching cycles (R6 setup once)", bad_sel, 0);
        chk(bad_oth == 0, "R7", "other strobe low cycles", bad_oth, 0);
        chk(bad_pulse == 0, "R8", "word_pulse mismatching cycles", bad_pulse, 0);
        chk(bad_done == 0, "R9", "done mismatching cycles", bad_done, 0);
        if (extra != "")
            chk(bad_sel + bad_oth + bad_pulse + bad_done == 0, extra, "burst mismatching cycles",
                bad_sel + bad_oth + bad_pulse + bad_done, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(dior_n === 1'b1 && diow_n === 1'b1, "R1", "strobes in reset", {dior_n, diow_n}, 3);
        rst = 1'b0;
        @(negedge clk);
        chk(dior_n === 1'b1 && diow_n === 1'b1, "R1", "strobes after reset", {dior_n, diow_n}, 3);
        chk(word_pulse === 1'b0 && done === 1'b0, "R1", "pulse/done after reset", {word_pulse, done}, 0);
        run_burst(1'b0, 1'b1, 0, 1'b0, "R1");

        cfg_write(32'hFFFF_FFFF, 1'b1);
        run_burst(1'b1, 1'b0, 1, 1'b0, "R3");
        run_burst(1'b0, 1'b1, 2, 1'b0, "R3");
        cfg_write(32'h0000_0000, 1'b0);
        run_burst(1'b0, 1'b0, 0, 1'b0, "R2");
        cfg_write(32'hFFFF_FFFF, 1'b0);
        run_burst(1'b1, 1'b1, 3, 1'b0, "R2");
        run_burst(1'b0, 1'b1, 2, 1'b1, "R10");
        run_burst(1'b1, 1'b0, 1, 1'b1, "R10");
        cfg_write(32'h0000_0421, 1'b1);
        run_burst(1'b0, 1'b0, 255, 1'b0, "R11");
        run_burst(1'b0, 1'b1, 3, 1'b0, "R6");

        for (int k = 0; k < 30; k++) begin
            if ($urandom % 2 == 0) cfg_write($urandom, bit'($urandom % 2));
            run_burst(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 6),
                      ($urandom % 4) == 0, "");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule